// File: doc/BRIEF.md
# Split-EOI Interrupt Completion Unit

This block retires interrupts for a single processor's interface of an interrupt controller. It records which interrupts are active in one bit per interrupt. It also keeps a stack of the priorities of the interrupts that are currently running. An acknowledge event from the surrounding controller marks an interrupt active and pushes its priority. Software then finishes the interrupt with register writes.

There are two ways to finish an interrupt. In joined mode, a write to the end-of-interrupt register lowers the running priority and also clears the interrupt's active bit. In split mode, that write only lowers the running priority, and a later write to a separate deactivate register clears the active bit. Split mode exists only when the `REVISION` parameter is 2. The mode bit that applies depends on the security of each access. A non-secure access cannot deactivate a group 0 interrupt.

All state updates and error pulses are registered. They become visible at the first clock edge after the write.

Top module: `splitEoiUnit`

## Requirements
- R1: In joined mode (the selected mode bit is 0, or `REVISION` is not 2), a write to offset 0x010 with an implemented interrupt number in data bits 9:0 pops the top priority and clears that interrupt's active bit. `runningPrio` shows the top stacked priority, or 0xFF when the stack is empty.
- R2: In split mode (`REVISION` is 2 and the selected mode bit is 1), an offset 0x010 write pops the priority and leaves the active bit set. A write to offset 0x1000 with the number in data bits 9:0 then clears that bit.
- R3: When `SECURITY` is nonzero and `wrSecure` is 0, the mode comes from `modeNs`. In every other case it comes from `modeSec`.
- R4: An offset 0x1000 write while the selected mode is joined changes no state and pulses `guestErr` for one cycle.
- R5: When `SECURITY` is nonzero, a non-secure offset 0x1000 write to an interrupt whose `groupMask` bit is 0 (group 0) is ignored and raises no flag.
- R6: Any write other than to 0x010, or to 0x1000 when `REVISION` is 2, pulses `badOffset` and changes no state. This includes writes at or beyond the window, which is 0x2000 bytes for revision 2 and 0x100 bytes otherwise.
- R7: Writes whose interrupt number is `NUM_IRQ` or higher are ignored by both the 0x010 and 0x1000 registers and raise no flag. This includes the reserved numbers 1020 to 1023.
- R8: The priority stack holds `DEPTH` (8) entries. An end-of-interrupt write on an empty stack is ignored and pulses `guestErr`. An acknowledge while the stack is full, without a pop in the same cycle, is dropped and pulses `guestErr`.
- R9: An acknowledge (`ackValid`, `ackId` below `NUM_IRQ`) sets the active bit of `ackId` and pushes `ackPrio`.
- R10: In one cycle, a pop happens before a push, so an acknowledge on a full stack succeeds together with an end-of-interrupt. An acknowledge of the same number overrides a clear of that number in the same cycle.
- R11: State, `runningPrio` and the flags change at the first clock edge after the write. The flags return to 0 after one cycle when no further error occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Register write strobe |
| wrAddr | input | 16 | Byte offset within the processor-interface window |
| wrData | input | 32 | Write data; bits 9:0 hold the interrupt number |
| wrSecure | input | 1 | 1 = secure access |
| modeSec | input | 1 | Split-mode bit used by secure accesses |
| modeNs | input | 1 | Split-mode bit used by non-secure accesses |
| groupMask | input | NUM_IRQ | Group per interrupt, 1 = group 1 |
| ackValid | input | 1 | Acknowledge event |
| ackId | input | 10 | Acknowledged interrupt number |
| ackPrio | input | 8 | Priority of the acknowledged interrupt |
| activeBits | output | NUM_IRQ | Active bit per interrupt |
| runningPrio | output | 8 | Top priority of the stack, 0xFF when empty |
| stackDepth | output | 4 | Number of stacked priorities |
| guestErr | output | 1 | One-cycle pulse on a misuse |
| badOffset | output | 1 | One-cycle pulse on an undecoded write |

## Verification
An acknowledge and a completion write can land in the same cycle. They contend for the priority stack and possibly for the same active bit. The bench provokes this with two cases. The first drives an acknowledge together with an end-of-interrupt on a full stack, and checks that the depth stays at eight, the new priority is on top and no error pulse appears. The second drives an acknowledge and a deactivate write for the same interrupt in split mode, and checks that the active bit stays set while the new priority is stacked.

// File: rtl/eoiPkg.sv
package eoiPkg;
  localparam int ID_W          = 10;
  localparam int PRIO_W        = 8;
  localparam int ADDR_W        = 16;
  localparam int SPURIOUS_BASE = 1020;
  localparam logic [ADDR_W-1:0] EOI_OFF = 16'h0010;
  localparam logic [ADDR_W-1:0] DIR_OFF = 16'h1000;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

  typedef struct packed {
    logic              pop;
    logic              push;
    logic              clr;
    logic [ID_W-1:0]   clrId;
    logic [ID_W-1:0]   pushId;
    logic [PRIO_W-1:0] pushPrio;
    logic              guestErr;
    logic              badOff;
  } dpStrobe_t;
endpackage

// File: rtl/eoiCtrl.sv
module eoiCtrl
  import eoiPkg::*;
#(
  parameter int NUM_IRQ  = 32,
  parameter int REVISION = 2,
  parameter int SECURITY = 1
) (
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              wrSecure,
  input  logic              modeSec,
  input  logic              modeNs,
  input  logic [NUM_IRQ-1:0] groupMask,
  input  logic              ackValid,
  input  logic [ID_W-1:0]   ackId,
  input  logic [PRIO_W-1:0] ackPrio,
  input  logic              stackEmpty,
  input  logic              stackFull,
  output dpStrobe_t         strobe
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ADDR_W:0] WINDOW = (REVISION == 2) ? 17'h2000 : 17'h100;
  localparam bit HAS_SPLIT = (REVISION == 2);
  localparam bit HAS_SEC   = (SECURITY != 0);

  logic unusedHi;
  assign unusedHi = ^wrData[31:ID_W];

  logic [ID_W-1:0]  wrId;
  logic [IDX_W-1:0] wrIdx;
  logic inWindow, isEoi, isDir, isSpurious, idImpl, idUsable;
  logic nsAccess, splitMode, targetGrp1;
  logic eoiPop, eoiEmptyErr, dirNoSplit, dirClear;
  logic ackIdOk, ackOk, ackRoom;

  assign wrId     = wrData[ID_W-1:0];
  assign wrIdx    = wrId[IDX_W-1:0];
  assign inWindow = {1'b0, wrAddr} < WINDOW;
  assign isEoi    = wrValid && inWindow && (wrAddr == EOI_OFF);
  assign isDir    = wrValid && inWindow && HAS_SPLIT && (wrAddr == DIR_OFF);

  assign isSpurious = 32'(wrId) >= SPURIOUS_BASE;
  assign idImpl     = 32'(wrId) < NUM_IRQ;
  assign idUsable   = idImpl && !isSpurious;

  assign nsAccess   = HAS_SEC && !wrSecure;
  assign splitMode  = HAS_SPLIT && (nsAccess ? modeNs : modeSec);
  assign targetGrp1 = groupMask[wrIdx];

  assign eoiPop      = isEoi && idUsable && !stackEmpty;
  assign eoiEmptyErr = isEoi && idUsable && stackEmpty;
  assign dirNoSplit  = isDir && idUsable && !splitMode;
  assign dirClear    = isDir && idUsable && splitMode && !(nsAccess && !targetGrp1);

  assign ackIdOk = 32'(ackId) < NUM_IRQ;
  assign ackOk   = ackValid && ackIdOk;
  assign ackRoom = !stackFull || eoiPop;

  always_comb begin
    strobe          = '0;
    strobe.pop      = eoiPop;
    strobe.clr      = (eoiPop && !splitMode) || dirClear;
    strobe.clrId    = wrId;
    strobe.push     = ackOk && ackRoom;
    strobe.pushId   = ackId;
    strobe.pushPrio = ackPrio;
    strobe.guestErr = eoiEmptyErr || dirNoSplit || (ackOk && !ackRoom);
    strobe.badOff   = wrValid && !isEoi && !isDir;
  end
endmodule

// File: rtl/eoiDatapath.sv
module eoiDatapath
  import eoiPkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  output logic [NUM_IRQ-1:0] activeBits,
  output logic [PRIO_W-1:0]  runningPrio,
  output logic [$clog2(DEPTH+1)-1:0] stackDepth,
  output logic               stackEmpty,
  output logic               stackFull,
  output logic               guestErr,
  output logic               badOffset
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [NUM_IRQ-1:0] activeQ, activeNext;
  logic [PRIO_W-1:0]  prioQ [DEPTH];
  logic [CNT_W-1:0]   cntQ, cntAfterPop, cntNext;
  logic [PRIO_W-1:0]  topPrio;
  logic               errQ, badQ;

  assign cntAfterPop = cntQ - CNT_W'(strobe.pop);
  assign cntNext     = cntAfterPop + CNT_W'(strobe.push);

  always_comb begin
    activeNext = activeQ;
    if (strobe.clr && (32'(strobe.clrId) < NUM_IRQ))
      activeNext[strobe.clrId[IDX_W-1:0]] = 1'b0;
    if (strobe.push && (32'(strobe.pushId) < NUM_IRQ))
      activeNext[strobe.pushId[IDX_W-1:0]] = 1'b1;
  end

  always_comb begin
    topPrio = IDLE_PRIO;
    for (int i = 0; i < DEPTH; i++)
      if (cntQ == CNT_W'(i + 1)) topPrio = prioQ[i];
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) prioQ[g] <= IDLE_PRIO;
        else if (strobe.push && (cntAfterPop == CNT_W'(g))) prioQ[g] <= strobe.pushPrio;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= '0;
      cntQ    <= '0;
      errQ    <= 1'b0;
      badQ    <= 1'b0;
    end else begin
      activeQ <= activeNext;
      cntQ    <= cntNext;
      errQ    <= strobe.guestErr;
      badQ    <= strobe.badOff;
    end
  end

  assign activeBits  = activeQ;
  assign runningPrio = topPrio;
  assign stackDepth  = cntQ;
  assign stackEmpty  = (cntQ == '0);
  assign stackFull   = (cntQ == CNT_W'(DEPTH));
  assign guestErr    = errQ;
  assign badOffset   = badQ;
endmodule

// File: rtl/splitEoiUnit.sv
module splitEoiUnit
  import eoiPkg::*;
#(
  parameter int NUM_IRQ  = 32,
  parameter int REVISION = 2,
  parameter int SECURITY = 1,
  parameter int DEPTH    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [31:0]        wrData,
  input  logic               wrSecure,
  input  logic               modeSec,
  input  logic               modeNs,
  input  logic [NUM_IRQ-1:0] groupMask,
  input  logic               ackValid,
  input  logic [ID_W-1:0]    ackId,
  input  logic [PRIO_W-1:0]  ackPrio,
  output logic [NUM_IRQ-1:0] activeBits,
  output logic [PRIO_W-1:0]  runningPrio,
  output logic [$clog2(DEPTH+1)-1:0] stackDepth,
  output logic               guestErr,
  output logic               badOffset
);
  dpStrobe_t strobe;
  logic stackEmpty, stackFull;

  eoiCtrl #(.NUM_IRQ(NUM_IRQ), .REVISION(REVISION), .SECURITY(SECURITY)) ctrlI (
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrSecure(wrSecure),
    .modeSec(modeSec), .modeNs(modeNs), .groupMask(groupMask),
    .ackValid(ackValid), .ackId(ackId), .ackPrio(ackPrio),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .strobe(strobe)
  );

  eoiDatapath #(.NUM_IRQ(NUM_IRQ), .DEPTH(DEPTH)) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .activeBits(activeBits), .runningPrio(runningPrio), .stackDepth(stackDepth),
    .stackEmpty(stackEmpty), .stackFull(stackFull),
    .guestErr(guestErr), .badOffset(badOffset)
  );
endmodule

// File: rtl/splitEoiUnitChk.sv
module splitEoiUnitChk
  import eoiPkg::*;
#(
  parameter int NUM_IRQ  = 32,
  parameter int REVISION = 2,
  parameter int SECURITY = 1,
  parameter int DEPTH    = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrValid,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [31:0]        wrData,
  input logic               wrSecure,
  input logic               modeSec,
  input logic               modeNs,
  input logic               ackValid,
  input logic [ID_W-1:0]    ackId,
  input logic [NUM_IRQ-1:0] activeBits,
  input logic [$clog2(DEPTH+1)-1:0] stackDepth,
  input logic               guestErr,
  input logic               badOffset
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam bit DIR_LIVE = (REVISION == 2);

  logic unusedChk;
  assign unusedChk = ^wrData[31:ID_W];

  logic [IDX_W-1:0] ackIdx;
  logic splitNow, idInRange, isEoiW, isDirW;
  assign ackIdx    = ackId[IDX_W-1:0];
  assign splitNow  = DIR_LIVE && (((SECURITY != 0) && !wrSecure) ? modeNs : modeSec);
  assign idInRange = 32'(wrData[ID_W-1:0]) < NUM_IRQ;
  assign isEoiW    = wrValid && (wrAddr == EOI_OFF);
  assign isDirW    = wrValid && DIR_LIVE && (wrAddr == DIR_OFF);

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(stackDepth) <= DEPTH);

  // R6
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !isEoiW && !isDirW) |=> badOffset);

  // R11
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && !ackValid) |=> (!guestErr && !badOffset));

  // R8
  empty_eoi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isEoiW && idInRange && stackDepth == '0 && !ackValid) |=> (guestErr && stackDepth == '0));

  // R4
  dir_nosplit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isDirW && idInRange && !splitNow && !ackValid) |=> (guestErr && $stable(activeBits)));

  // R9
  ack_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && 32'(ackId) < NUM_IRQ && 32'(stackDepth) < DEPTH) |=> activeBits[$past(ackIdx)]);
endmodule

bind splitEoiUnit splitEoiUnitChk #(
  .NUM_IRQ(NUM_IRQ), .REVISION(REVISION), .SECURITY(SECURITY), .DEPTH(DEPTH)
) chkI (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
  .wrSecure(wrSecure), .modeSec(modeSec), .modeNs(modeNs),
  .ackValid(ackValid), .ackId(ackId), .activeBits(activeBits),
  .stackDepth(stackDepth), .guestErr(guestErr), .badOffset(badOffset)
);

// File: tb/splitEoiUnit_tb_top.sv
`timescale 1ns/1ps
module splitEoiUnit_tb_top;
  localparam int NIRQ = 32;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrValid, wrSecure, modeSec, modeNs, ackValid;
  logic [15:0] wrAddr;
  logic [31:0] wrData;
  logic [NIRQ-1:0] groupMask;
  logic [9:0]  ackId;
  logic [7:0]  ackPrio;
  logic [NIRQ-1:0] activeBits;
  logic [7:0]  runningPrio;
  logic [3:0]  stackDepth;
  logic        guestErr, badOffset;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  splitEoiUnit dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrSecure(wrSecure), .modeSec(modeSec), .modeNs(modeNs), .groupMask(groupMask),
    .ackValid(ackValid), .ackId(ackId), .ackPrio(ackPrio),
    .activeBits(activeBits), .runningPrio(runningPrio), .stackDepth(stackDepth),
    .guestErr(guestErr), .badOffset(badOffset)
  );

  // op: 0 acknowledge, 1 end-of-interrupt (0x010), 2 deactivate (0x1000), 3 raw write to addr
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [9:0]  id;
    logic [7:0]  prio;
    logic        sec;
    logic        mS;
    logic        mN;
    logic [9:0]  chkId;
    logic        expAct;
    logic [7:0]  expRun;
    logic        expErr;
    logic        expBad;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 16'h0, 10'd3,    8'h40, 1'b1, 1'b0, 1'b0, 10'd3,  1'b1, 8'h40, 1'b0, 1'b0}, // R9
    '{2'd0, 16'h0, 10'd20,   8'h20, 1'b1, 1'b0, 1'b0, 10'd20, 1'b1, 8'h20, 1'b0, 1'b0}, // R9
    '{2'd1, 16'h0, 10'd20,   8'h00, 1'b1, 1'b0, 1'b0, 10'd20, 1'b0, 8'h40, 1'b0, 1'b0}, // R1
    '{2'd1, 16'h0, 10'd3,    8'h00, 1'b1, 1'b0, 1'b0, 10'd3,  1'b0, 8'hFF, 1'b0, 1'b0}, // R1
    '{2'd1, 16'h0, 10'd3,    8'h00, 1'b1, 1'b0, 1'b0, 10'd3,  1'b0, 8'hFF, 1'b1, 1'b0}, // R8
    '{2'd0, 16'h0, 10'd5,    8'h30, 1'b1, 1'b1, 1'b0, 10'd5,  1'b1, 8'h30, 1'b0, 1'b0}, // R9
    '{2'd1, 16'h0, 10'd5,    8'h00, 1'b1, 1'b1, 1'b0, 10'd5,  1'b1, 8'hFF, 1'b0, 1'b0}, // R2
    '{2'd2, 16'h0, 10'd5,    8'h00, 1'b1, 1'b1, 1'b0, 10'd5,  1'b0, 8'hFF, 1'b0, 1'b0}, // R2
    '{2'd0, 16'h0, 10'd18,   8'h50, 1'b1, 1'b0, 1'b1, 10'd18, 1'b1, 8'h50, 1'b0, 1'b0}, // R9
    '{2'd1, 16'h0, 10'd18,   8'h00, 1'b0, 1'b0, 1'b1, 10'd18, 1'b1, 8'hFF, 1'b0, 1'b0}, // R3
    '{2'd2, 16'h0, 10'd18,   8'h00, 1'b0, 1'b0, 1'b1, 10'd18, 1'b1, 8'hFF, 1'b0, 1'b0}, // R5
    '{2'd2, 16'h0, 10'd18,   8'h00, 1'b1, 1'b0, 1'b1, 10'd18, 1'b1, 8'hFF, 1'b1, 1'b0}, // R4
    '{2'd2, 16'h0, 10'd18,   8'h00, 1'b1, 1'b1, 1'b0, 10'd18, 1'b0, 8'hFF, 1'b0, 1'b0}, // R2
    '{2'd0, 16'h0, 10'd7,    8'h10, 1'b0, 1'b0, 1'b1, 10'd7,  1'b1, 8'h10, 1'b0, 1'b0}, // R9
    '{2'd1, 16'h0, 10'd7,    8'h00, 1'b0, 1'b0, 1'b1, 10'd7,  1'b1, 8'hFF, 1'b0, 1'b0}, // R3
    '{2'd2, 16'h0, 10'd7,    8'h00, 1'b0, 1'b0, 1'b1, 10'd7,  1'b0, 8'hFF, 1'b0, 1'b0}, // R5
    '{2'd0, 16'h0, 10'd9,    8'h22, 1'b0, 1'b1, 1'b0, 10'd9,  1'b1, 8'h22, 1'b0, 1'b0}, // R9
    '{2'd1, 16'h0, 10'd9,    8'h00, 1'b0, 1'b1, 1'b0, 10'd9,  1'b0, 8'hFF, 1'b0, 1'b0}, // R3
    '{2'd2, 16'h0, 10'd1020, 8'h00, 1'b1, 1'b1, 1'b0, 10'd0,  1'b0, 8'hFF, 1'b0, 1'b0}, // R7
    '{2'd3, 16'h8, 10'd0,    8'h00, 1'b1, 1'b0, 1'b0, 10'd0,  1'b0, 8'hFF, 1'b0, 1'b1}, // R6
    '{2'd3, 16'h2000, 10'd0, 8'h00, 1'b1, 1'b0, 1'b0, 10'd0,  1'b0, 8'hFF, 1'b0, 1'b1}  // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrValid = 1'b0; ackValid = 1'b0; wrAddr = '0; wrData = '0;
    ackId = '0; ackPrio = '0;
  endtask

  // drives one cycle of stimulus; returns at the next falling edge, after the registering edge
  task automatic step(input logic aV, input logic [9:0] aId, input logic [7:0] aP,
                      input logic wV, input logic [15:0] addr, input logic [9:0] id,
                      input logic sec, input logic mS, input logic mN);
    @(negedge clk);
    ackValid = aV; ackId = aId; ackPrio = aP;
    wrValid = wV; wrAddr = addr; wrData = {22'd0, id};
    wrSecure = sec; modeSec = mS; modeNs = mN;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    wrSecure = 1'b1; modeSec = 1'b0; modeNs = 1'b0;
    groupMask = 32'h0000FFFF; // ids 0..15 group 1, 16..31 group 0
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset / idle state
    check("R1 reset active", activeBits, 32'h0);
    check("R1 reset running", runningPrio, 8'hFF);
    check("R8 reset depth", stackDepth, 0);
    check("R11 reset flags", {guestErr, badOffset}, 0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = TBL[k];
      case (v.op)
        2'd0: step(1'b1, v.id, v.prio, 1'b0, 16'h0, 10'd0, v.sec, v.mS, v.mN);
        2'd1: step(1'b0, 10'd0, 8'h0, 1'b1, 16'h0010, v.id, v.sec, v.mS, v.mN);
        2'd2: step(1'b0, 10'd0, 8'h0, 1'b1, 16'h1000, v.id, v.sec, v.mS, v.mN);
        default: step(1'b0, 10'd0, 8'h0, 1'b1, v.addr, v.id, v.sec, v.mS, v.mN);
      endcase
      check($sformatf("row%0d active", k), 32'(activeBits[v.chkId[4:0]]), 32'(v.expAct));
      check($sformatf("row%0d running", k), runningPrio, v.expRun);
      check($sformatf("row%0d guestErr", k), guestErr, v.expErr);
      check($sformatf("row%0d badOffset", k), badOffset, v.expBad);
    end

    // R10 acknowledge and completion in one cycle
    step(1'b1, 10'd3, 8'h40, 1'b0, 16'h0, 10'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 10'd9, 8'h60, 1'b1, 16'h0010, 10'd3, 1'b1, 1'b0, 1'b0);
    check("R10 pop then push running", runningPrio, 8'h60);
    check("R10 pop then push depth", stackDepth, 1);
    check("R10 cleared id3", activeBits[3], 0);
    check("R10 set id9", activeBits[9], 1);
    step(1'b1, 10'd9, 8'h70, 1'b1, 16'h1000, 10'd9, 1'b1, 1'b1, 1'b0);
    check("R10 ack beats clear", activeBits[9], 1);
    check("R10 ack with deactivate depth", stackDepth, 2);
    step(1'b0, 10'd0, 8'h0, 1'b1, 16'h0010, 10'd9, 1'b1, 1'b0, 1'b0);
    step(1'b0, 10'd0, 8'h0, 1'b1, 16'h0010, 10'd9, 1'b1, 1'b0, 1'b0);
    check("R1 drained", stackDepth, 0);
    check("R1 drained active", activeBits, 32'h0);

    // R8 full stack
    for (int i = 0; i < 8; i++)
      step(1'b1, 10'(i), 8'(8'h80 - i), 1'b0, 16'h0, 10'd0, 1'b1, 1'b0, 1'b0);
    check("R8 full depth", stackDepth, 8);
    check("R8 full top", runningPrio, 8'h79);
    step(1'b1, 10'd10, 8'h05, 1'b0, 16'h0, 10'd0, 1'b1, 1'b0, 1'b0);
    check("R8 overflow err", guestErr, 1);
    check("R8 overflow dropped", activeBits[10], 0);
    check("R8 overflow depth", stackDepth, 8);
    step(1'b1, 10'd11, 8'h05, 1'b1, 16'h0010, 10'd7, 1'b1, 1'b0, 1'b0);
    check("R11 flag returns low", guestErr, 0);
    check("R10 full swap depth", stackDepth, 8);
    check("R10 full swap top", runningPrio, 8'h05);
    check("R10 full swap set", activeBits[11], 1);
    check("R10 full swap clear", activeBits[7], 0);
    for (int i = 0; i < 8; i++)
      step(1'b0, 10'd0, 8'h0, 1'b1, 16'h0010, 10'd31, 1'b1, 1'b0, 1'b0);
    check("R8 emptied", stackDepth, 0);

    // R7 out-of-range numbers leave a live stack alone
    step(1'b1, 10'd2, 8'h33, 1'b0, 16'h0, 10'd0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 10'd0, 8'h0, 1'b1, 16'h0010, 10'd1023, 1'b1, 1'b0, 1'b0);
    check("R7 spurious EOI running", runningPrio, 8'h33);
    check("R7 spurious EOI flags", {guestErr, badOffset}, 0);
    step(1'b0, 10'd0, 8'h0, 1'b1, 16'h0010, 10'd40, 1'b1, 1'b0, 1'b0);
    check("R7 unimplemented EOI depth", stackDepth, 1);
    step(1'b0, 10'd0, 8'h0, 1'b1, 16'h1000, 10'd40, 1'b1, 1'b1, 1'b0);
    check("R7 unimplemented deactivate flags", {guestErr, badOffset}, 0);
    check("R7 id2 still active", activeBits[2], 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule